// File: doc/BRIEF.md
# DMA Bus Handover Controller with Write Snooping

This block sits on the processor side of a shared system bus and decides when a DMA device may take the bus and when the processor takes it back. A device asks for the bus by raising a request. If a local bus cycle is in progress, the controller lets that cycle run to its last clock. Only then does it raise the grant. The device answers with a grant acknowledge. From then on the controller watches every DMA write on the snooped address, data and write-enable lines. It checks each write against a small, fully associative tag store of locally cached words.

When a snooped write matches a valid entry, the controller acts according to a mode input. In invalidate mode it clears the entry's valid bit. In update mode it overwrites the entry's data with the written value. The device ends its tenure by raising release. The controller answers with a release acknowledge and holds it until the device has dropped request, acknowledge and release. It then gives the bus back to the processor. A processor bus cycle that was requested while the bus was away starts on the first clock the bus is owned again. The tag store is filled, and read back, through a fill port and a combinational lookup port on the processor side.

The handover state machine has four states. ST_OWN means the processor owns the bus and may run cycles. ST_GRANT means the grant is raised and the controller is waiting for the acknowledge. ST_SNOOP means the device owns the bus and its writes are snooped. ST_RACK means the release acknowledge is raised.

The transitions are:
- ST_OWN to ST_GRANT when a request is seen and no cycle is busy.
- ST_GRANT to ST_SNOOP on the acknowledge.
- ST_SNOOP to ST_RACK on release.
- ST_RACK to ST_OWN once release and request are both low.

The bus cycle sequencer is a down-counter. It is idle at zero, loads CYC_LEN when a cycle starts, and flags the cycle's last clock when it reaches one.

Top module: `dma_handover_ctrl`

## Requirements
- R1: With the processor idle (no bus cycle busy) and in ST_OWN, a request sampled at a clock edge makes dma_gnt high right after that edge.
- R2: A request that arrives during a processor bus cycle leaves dma_gnt low until that cycle's last clock (core_done high) has passed; dma_gnt rises one clock after it. No new processor cycle starts while dma_req is high.
- R3: dma_gnt stays high from grant until release is seen. Snooped writes before dma_gack is seen (state ST_GRANT) have no effect: snp_hit stays 0 and the tag store is unchanged.
- R4: In ST_SNOOP, a write (snp_we=1) whose address equals the tag of a valid entry drives snp_hit high in the same cycle. A write to an address in no valid entry drives snp_hit low and changes no entry.
- R5: With snoop_update=0 (invalidate mode), a snooped hit clears that entry's valid bit, so a later lookup of that address misses.
- R6: With snoop_update=1 (update mode), a snooped hit keeps the entry valid and replaces its data with snp_data.
- R7: cpu_bus_en is low from the edge that raises dma_gnt until the edge that lowers dma_rack, and high at all other times.
- R8: dma_rel raises dma_rack one clock later, and dma_gnt drops on that same edge. dma_rack stays high while dma_rel or dma_req is high, and falls one clock after both are low.
- R9: A processor cycle requested (core_req held high) while the bus is away starts on the first edge after ownership returns, so core_done is high in the third clock after that start edge (for CYC_LEN=3).
- R10: A processor bus cycle lasts CYC_LEN clocks. core_done is high only in its last clock.
- R11: After reset, dma_gnt=0, dma_rack=0, cpu_bus_en=1, core_done=0 and every tag entry is invalid.
- R12: fill_en writes fill_addr and fill_data into entry fill_idx and marks it valid. A lookup of that address then gives lk_hit=1 and lk_data equal to the filled data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Processor wants a bus cycle; held until core_done |
| core_done | output | 1 | Last clock of the processor bus cycle |
| cpu_bus_en | output | 1 | Processor may drive the bus |
| dma_req | input | 1 | Bus request from the DMA device |
| dma_gnt | output | 1 | Bus grant to the device |
| dma_gack | input | 1 | Grant acknowledge from the device |
| dma_rel | input | 1 | Bus release from the device |
| dma_rack | output | 1 | Release acknowledge to the device |
| snoop_update | input | 1 | Snoop policy: 1 update data, 0 invalidate |
| snp_we | input | 1 | Snooped bus write strobe |
| snp_addr | input | AW | Snooped write address |
| snp_data | input | DW | Snooped write data |
| snp_hit | output | 1 | Snooped write matched a valid entry this cycle |
| fill_en | input | 1 | Write an entry of the tag store |
| fill_idx | input | IW | Entry index to fill |
| fill_addr | input | AW | Address tag to fill |
| fill_data | input | DW | Data to fill |
| lk_addr | input | AW | Lookup address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_data | output | DW | Data of the matching entry, zero on a miss |

## Verification
The assertions take three things for granted about the inputs. Valid tags in the store are distinct, so at most one entry can match a snooped write. fill_en is only raised while the processor owns the bus. The device follows the four-phase order: acknowledge after grant, release after acknowledge, and all three dropped during the release acknowledge. The stimulus fills distinct tags spaced 0x20 apart and fills only in ST_OWN. It drives the handshake inputs one step at a time in that order, with each step waiting for the controller's previous answer.

// File: rtl/dma_hov_pkg.sv
package dma_hov_pkg;

    typedef enum logic [1:0] {
        ST_OWN   = 2'd0,
        ST_GRANT = 2'd1,
        ST_SNOOP = 2'd2,
        ST_RACK  = 2'd3
    } hov_state_e;

endpackage

// File: rtl/dma_hov_cycle.sv
module dma_hov_cycle #(
    parameter int CYC_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic own_bus,
    input  logic dma_req,
    input  logic core_req,
    output logic cyc_busy,
    output logic core_done
);

    localparam int CW = $clog2(CYC_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC_LEN);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] t_left;
    logic          start;

    // A new cycle needs the bus, an idle sequencer and no pending DMA request.
    assign start = own_bus && core_req && !dma_req && (t_left == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_left <= '0;
        end else if (start) begin
            t_left <= LOAD;
        end else if (t_left != '0) begin
            t_left <= t_left - ONE;
        end
    end

    assign cyc_busy  = (t_left != '0);
    assign core_done = (t_left == ONE);

    // R10: the count only ever moves down by one, or is loaded from idle.
    a_r10_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(t_left) != '0) |-> (t_left == $past(t_left) - ONE));

    // R2: a cycle never starts while a DMA request is pending.
    a_r2_no_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_busy) |-> !$past(dma_req));

endmodule

// File: rtl/dma_hov_tags.sv
module dma_hov_tags #(
    parameter int ENTRIES = 4,
    parameter int AW      = 8,
    parameter int DW      = 8,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_en,
    input  logic [IW-1:0] fill_idx,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic          snoop_on,
    input  logic          snoop_update,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    output logic          snp_hit,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data
);

    logic [ENTRIES-1:0] vld;
    logic [AW-1:0]      tag [ENTRIES];
    logic [DW-1:0]      dat [ENTRIES];
    logic [ENTRIES-1:0] hitv;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        logic fill_me;

        assign fill_me = fill_en && (fill_idx == IW'(i));
        assign hitv[i] = snoop_on && snp_we && vld[i] && (tag[i] == snp_addr);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
                tag[i] <= '0;
                dat[i] <= '0;
            end else if (fill_me) begin
                vld[i] <= 1'b1;
                tag[i] <= fill_addr;
                dat[i] <= fill_data;
            end else if (hitv[i]) begin
                if (snoop_update) begin
                    dat[i] <= snp_data;
                end else begin
                    vld[i] <= 1'b0;
                end
            end
        end

        // R5: an invalidating hit leaves the entry invalid.
        a_r5_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
            (hitv[i] && !snoop_update && !fill_me) |=> !vld[i]);

        // R6: an updating hit keeps the entry and takes the written data.
        a_r6_update: assert property (@(posedge clk) disable iff (!rst_n)
            (hitv[i] && snoop_update && !fill_me) |=> (vld[i] && dat[i] == $past(snp_data)));
    end

    assign snp_hit = |hitv;

    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (vld[j] && tag[j] == lk_addr) begin
                lk_hit  = 1'b1;
                lk_data = lk_data | dat[j];
            end
        end
    end

    // R4: distinct tags mean at most one entry answers a snooped write.
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hitv));

    // R3: nothing is snooped unless the device has acknowledged the grant.
    a_r3_snoop_gated: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |-> snoop_on);

endmodule

// File: rtl/dma_hov_fsm.sv
module dma_hov_fsm
    import dma_hov_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_req,
    input  logic       dma_gack,
    input  logic       dma_rel,
    input  logic       cyc_busy,
    output hov_state_e state,
    output logic       dma_gnt,
    output logic       dma_rack,
    output logic       own_bus,
    output logic       snoop_on
);

    hov_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OWN:   if (dma_req && !cyc_busy) nxt = ST_GRANT;
            ST_GRANT: if (dma_gack)             nxt = ST_SNOOP;
            ST_SNOOP: if (dma_rel)              nxt = ST_RACK;
            ST_RACK:  if (!dma_rel && !dma_req) nxt = ST_OWN;
            default:                            nxt = ST_OWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OWN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        dma_gnt  = 1'b0;
        dma_rack = 1'b0;
        own_bus  = 1'b0;
        snoop_on = 1'b0;
        unique case (state)
            ST_OWN:   own_bus  = 1'b1;
            ST_GRANT: dma_gnt  = 1'b1;
            ST_SNOOP: begin
                dma_gnt  = 1'b1;
                snoop_on = 1'b1;
            end
            ST_RACK:  dma_rack = 1'b1;
            default:  own_bus  = 1'b1;
        endcase
    end

    // R8: the release acknowledge only answers a release.
    a_r8_rack_after_rel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rack) |-> $past(dma_rel));

    // R8: the acknowledge holds while the device still drives release or request.
    a_r8_rack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rack && (dma_rel || dma_req)) |=> dma_rack);

    // R3: the grant is kept until release is seen.
    a_r3_gnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && !dma_rel) |=> dma_gnt);

endmodule

// File: rtl/dma_handover_ctrl.sv
module dma_handover_ctrl
    import dma_hov_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int CYC_LEN = 3,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    output logic          core_done,
    output logic          cpu_bus_en,
    input  logic          dma_req,
    output logic          dma_gnt,
    input  logic          dma_gack,
    input  logic          dma_rel,
    output logic          dma_rack,
    input  logic          snoop_update,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    output logic          snp_hit,
    input  logic          fill_en,
    input  logic [IW-1:0] fill_idx,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data
);

    hov_state_e state;
    logic       own_bus;
    logic       snoop_on;
    logic       cyc_busy;

    dma_hov_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_req  (dma_req),
        .dma_gack (dma_gack),
        .dma_rel  (dma_rel),
        .cyc_busy (cyc_busy),
        .state    (state),
        .dma_gnt  (dma_gnt),
        .dma_rack (dma_rack),
        .own_bus  (own_bus),
        .snoop_on (snoop_on)
    );

    dma_hov_cycle #(.CYC_LEN(CYC_LEN)) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_bus   (own_bus),
        .dma_req   (dma_req),
        .core_req  (core_req),
        .cyc_busy  (cyc_busy),
        .core_done (core_done)
    );

    dma_hov_tags #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_en      (fill_en),
        .fill_idx     (fill_idx),
        .fill_addr    (fill_addr),
        .fill_data    (fill_data),
        .snoop_on     (snoop_on),
        .snoop_update (snoop_update),
        .snp_we       (snp_we),
        .snp_addr     (snp_addr),
        .snp_data     (snp_data),
        .snp_hit      (snp_hit),
        .lk_addr      (lk_addr),
        .lk_hit       (lk_hit),
        .lk_data      (lk_data)
    );

    assign cpu_bus_en = own_bus;

    // R1: an idle processor grants on the next edge.
    a_r1_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_bus_en && dma_req && !cyc_busy) |=> dma_gnt);

    // R2: the grant never rises while a processor cycle was still running.
    a_r2_finish_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_gnt) |-> !$past(cyc_busy));

    // R7: the processor does not drive the bus during any part of the handover.
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt || dma_rack) |-> !cpu_bus_en);

    // R9: a processor cycle only starts while the processor owns the bus.
    a_r9_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_busy) |-> cpu_bus_en);

    // R12: fills happen only while the processor owns the bus (input rule).
    a_r12_fill_owned: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> cpu_bus_en);

endmodule

// File: tb/dma_handover_ctrl_test.sv
module dma_handover_ctrl_test;

    localparam int ENTRIES = 4;
    localparam int AW      = 8;
    localparam int DW      = 8;
    localparam int CYC_LEN = 3;
    localparam int IW      = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req = 1'b0;
    logic          core_done;
    logic          cpu_bus_en;
    logic          dma_req = 1'b0;
    logic          dma_gnt;
    logic          dma_gack = 1'b0;
    logic          dma_rel = 1'b0;
    logic          dma_rack;
    logic          snoop_update = 1'b0;
    logic          snp_we = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_hit;
    logic          fill_en = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_handover_ctrl #(
        .ENTRIES(ENTRIES), .AW(AW), .DW(DW), .CYC_LEN(CYC_LEN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_done(core_done),
        .cpu_bus_en(cpu_bus_en), .dma_req(dma_req), .dma_gnt(dma_gnt),
        .dma_gack(dma_gack), .dma_rel(dma_rel), .dma_rack(dma_rack),
        .snoop_update(snoop_update), .snp_we(snp_we), .snp_addr(snp_addr),
        .snp_data(snp_data), .snp_hit(snp_hit), .fill_en(fill_en),
        .fill_idx(fill_idx), .fill_addr(fill_addr), .fill_data(fill_data),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
    );

    function automatic int tag_of(int i);
        return 8'h11 + i * 8'h20;
    endfunction

    function automatic int dat_of(int i);
        return 8'h05 + i * 7;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic negs(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look(string req, int addr, int exp_hit, int exp_data);
        lk_addr = AW'(addr);
        #1;
        chk(req, int'(lk_hit), exp_hit);
        if (exp_hit != 0) chk(req, int'(lk_data), exp_data);
    endtask

    task automatic fill_all();
        for (int i = 0; i < ENTRIES; i++) begin
            fill_en   = 1'b1;
            fill_idx  = IW'(i);
            fill_addr = AW'(tag_of(i));
            fill_data = DW'(dat_of(i));
            negs(1);
        end
        fill_en = 1'b0;
    endtask

    // One full handover with a pre-acknowledge write and a snooped write.
    task automatic handover(int addr, int data, int exp_hit);
        dma_req = 1'b1;
        negs(1);
        chk("R1 grant next clock", int'(dma_gnt), 1);
        chk("R7 bus released at grant", int'(cpu_bus_en), 0);
        snp_we = 1'b1; snp_addr = AW'(addr); snp_data = 8'h99;
        #1;
        chk("R3 no snoop before ack", int'(snp_hit), 0);
        negs(1);
        snp_we = 1'b0;
        chk("R3 grant held", int'(dma_gnt), 1);
        dma_gack = 1'b1;
        negs(1);
        snp_we = 1'b1; snp_addr = AW'(addr); snp_data = DW'(data);
        #1;
        chk("R4 snoop hit flag", int'(snp_hit), exp_hit);
        negs(1);
        snp_we = 1'b0;
        dma_rel = 1'b1;
        negs(1);
        chk("R8 rack after release", int'(dma_rack), 1);
        chk("R8 grant drops", int'(dma_gnt), 0);
        chk("R7 bus still released", int'(cpu_bus_en), 0);
        negs(1);
        chk("R8 rack held", int'(dma_rack), 1);
        dma_req = 1'b0; dma_gack = 1'b0; dma_rel = 1'b0;
        negs(1);
        chk("R8 rack falls", int'(dma_rack), 0);
        chk("R7 bus back", int'(cpu_bus_en), 1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        negs(3);
        rst_n = 1'b1;
        negs(1);
        // R11 reset state
        chk("R11 gnt", int'(dma_gnt), 0);
        chk("R11 rack", int'(dma_rack), 0);
        chk("R11 bus_en", int'(cpu_bus_en), 1);
        chk("R11 done", int'(core_done), 0);
        for (int i = 0; i < ENTRIES; i++) look("R11 entries invalid", tag_of(i), 0, 0);

        fill_all();
        for (int i = 0; i < ENTRIES; i++) look("R12 fill lookup", tag_of(i), 1, dat_of(i));

        // R10 idle bus cycle of CYC_LEN clocks
        core_req = 1'b1;
        for (int t = 1; t <= CYC_LEN + 1; t++) begin
            negs(1);
            chk("R10 done timing", int'(core_done), (t == CYC_LEN) ? 1 : 0);
            if (t == CYC_LEN) core_req = 1'b0;
        end

        // R2 request during a cycle waits for its end
        core_req = 1'b1;
        negs(1);
        dma_req = 1'b1;
        for (int t = 2; t <= CYC_LEN + 2; t++) begin
            negs(1);
            if (t == CYC_LEN) begin
                chk("R2 done seen", int'(core_done), 1);
                core_req = 1'b0;
            end
            chk("R2 grant after cycle", int'(dma_gnt), (t == CYC_LEN + 2) ? 1 : 0);
        end
        dma_gack = 1'b1; negs(1);
        dma_rel = 1'b1;  negs(1);
        dma_req = 1'b0; dma_gack = 1'b0; dma_rel = 1'b0;
        negs(1);
        chk("R2 bus returned", int'(cpu_bus_en), 1);

        // Sweep: both policies, every entry, plus a miss
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k <= ENTRIES; k++) begin
                int addr;
                int wdat;
                fill_all();
                snoop_update = m[0];
                addr = (k < ENTRIES) ? tag_of(k) : 8'hFE;
                wdat = 8'hC0 + k + m * 8;
                handover(addr, wdat, (k < ENTRIES) ? 1 : 0);
                for (int j = 0; j < ENTRIES; j++) begin
                    if (j != k) look("R4 other entries unchanged", tag_of(j), 1, dat_of(j));
                    else if (m == 0) look("R5 invalidated", tag_of(j), 0, 0);
                    else look("R6 updated", tag_of(j), 1, wdat);
                end
            end
        end

        // R9 cycle requested during DMA resumes after return
        core_req = 1'b1;
        dma_req = 1'b1;
        negs(1);
        chk("R9 dma wins", int'(dma_gnt), 1);
        dma_gack = 1'b1; negs(1);
        chk("R9 no done during dma", int'(core_done), 0);
        dma_rel = 1'b1;  negs(1);
        dma_req = 1'b0; dma_gack = 1'b0; dma_rel = 1'b0;
        negs(1);
        chk("R9 owned again", int'(cpu_bus_en), 1);
        for (int t = 1; t <= CYC_LEN; t++) begin
            negs(1);
            chk("R9 resumed cycle", int'(core_done), (t == CYC_LEN) ? 1 : 0);
        end
        core_req = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule